// File: doc/BRIEF.md
# Serial-Wire / JTAG Port Mode Selector

This block watches the single shared mode/data line of a combined serial-wire and JTAG debug port and decides which of the two protocols currently owns the port. It samples the line on every rising edge of the debug clock. A long run of high samples counts as a line reset. A 16-bit select code that follows a line reset picks the next mode. A second run of high samples after the code commits the switch.

Select codes arrive least-significant bit first. Two codes ask for serial-wire mode and two ask for JTAG mode: a current pair and an older, deprecated pair. After power-on reset the port is in JTAG mode. The block reports the active mode, pulses a change strobe for one cycle whenever the mode flips, and on entry to JTAG mode pulses a request that the TAP controller return to Test-Logic-Reset. The TAP controller and the serial-wire packet engine sit next to this block and are not part of it.

Top module: `swj_mode_detect`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `mode_swd` is 0 (JTAG mode), and `mode_chg` and `tap_rst_req` are 0.
- R2: A line reset is 50 consecutive rising-edge samples of `swdio_in` equal to 1. A run of 49 ones followed by a 0 is not a line reset, and a code that follows such a run is ignored.
- R3: A code is captured least-significant bit first: the first sampled bit is bit 0. The value 0xE79E selects serial-wire mode and 0xE73C selects JTAG mode.
- R4: The deprecated codes are also honoured: 0xEDB6 selects serial-wire mode and 0xDEAE selects JTAG mode.
- R5: A code is only considered when its first bit, a 0, is the first 0 after a line reset. A 16-bit value that is none of the four codes leaves the mode unchanged, and no code is matched again until a new line reset has been seen.
- R6: An accepted code takes effect on the rising edge that samples the 50th consecutive 1 after the code's last bit, and the outputs show the new state right after that edge. A 0 sampled before that point cancels the pending switch.
- R7: `mode_chg` is high for exactly one cycle, in the same cycle that `mode_swd` takes its new value. A code that asks for the mode already active is accepted and gives no pulse.
- R8: `tap_rst_req` is high for exactly one cycle, together with `mode_chg`, each time JTAG mode is entered, and at no other time.
- R9: The run-of-ones counter saturates at 63. An arbitrarily long high period produces no further line-reset events, no output pulses and no wrap, and a valid code after it is still honoured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Debug clock; the line is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| swdio_in | input | 1 | Shared mode-select / serial data line as seen by the target |
| mode_swd | output | 1 | Active mode: 1 = serial-wire, 0 = JTAG |
| mode_chg | output | 1 | One-cycle pulse when the active mode changes |
| tap_rst_req | output | 1 | One-cycle request to force the TAP into Test-Logic-Reset on JTAG entry |

## Verification
The bench runs every code in both directions, including the deprecated ones. It checks the exact edge at which the switch commits; a design that counted the code's own trailing ones toward the second line reset would switch several cycles early. It sends an unknown pattern followed at once by a valid code; a design that did not drop its armed state would switch on that code. It also covers a 49-one run, a 0 inside the trailing run and a same-mode request, which would expose an off-by-one threshold, a switch that cannot be cancelled, and a spurious change strobe. A 200-cycle idle-high stretch follows, and a counter that wraps would fire extra line-reset events there.

// File: rtl/swj_sel_pkg.sv
package swj_sel_pkg;

    localparam int CODE_W = 16;

    localparam logic [CODE_W-1:0] SEL_SWD_NEW  = 16'hE79E;
    localparam logic [CODE_W-1:0] SEL_JTAG_NEW = 16'hE73C;
    localparam logic [CODE_W-1:0] SEL_SWD_OLD  = 16'hEDB6;
    localparam logic [CODE_W-1:0] SEL_JTAG_OLD = 16'hDEAE;

    typedef enum logic [1:0] {
        ST_IDLE,   // waiting for a line reset
        ST_ARMED,  // line reset seen, line still high
        ST_SHIFT,  // collecting select code bits
        ST_TRAIL   // code accepted, waiting for trailing line reset
    } det_state_e;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_TO_SWD,
        SEL_TO_JTAG
    } sel_kind_e;

    typedef struct packed {
        logic swd;
        logic chg;
        logic tap;
    } mode_out_t;

    function automatic sel_kind_e classify_code(input logic [CODE_W-1:0] c);
        sel_kind_e k;
        case (c)
            SEL_SWD_NEW,  SEL_SWD_OLD:  k = SEL_TO_SWD;
            SEL_JTAG_NEW, SEL_JTAG_OLD: k = SEL_TO_JTAG;
            default:                    k = SEL_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/swj_run_counter.sv
module swj_run_counter #(
    parameter int CNT_W     = 6,
    parameter int RESET_LEN = 50
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    input  logic             clr,
    output logic [CNT_W-1:0] run_o,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] RUN_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] HIT_PREV = CNT_W'(RESET_LEN - 1);

    logic [CNT_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || clr || !bit_in) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign run_o = run_q;
    assign hit_o = bit_in && !clr && (run_q == HIT_PREV);

endmodule

// File: rtl/swj_code_shift.sv
module swj_code_shift #(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              start,
    input  logic              active,
    output logic [CODE_W-1:0] code_o,
    output logic              done_o
);
    localparam int IDX_W = $clog2(CODE_W + 1);

    logic [CODE_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CODE_W-1:0] word_next;

    assign word_next = {bit_in, sh_q[CODE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (start) begin
            sh_q  <= word_next;
            idx_q <= IDX_W'(1);
        end else if (active) begin
            sh_q  <= word_next;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign code_o = word_next;
    assign done_o = active && (idx_q == IDX_W'(CODE_W - 1));

endmodule

// File: rtl/swj_mode_detect.sv
module swj_mode_detect
    import swj_sel_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int RESET_LEN = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic swdio_in,
    output logic mode_swd,
    output logic mode_chg,
    output logic tap_rst_req
);
    det_state_e        st_q, st_d;
    logic              pend_swd_q, pend_swd_d;
    mode_out_t         out_q, out_d;
    logic [CNT_W-1:0]  run_cnt;
    logic              lr_hit;
    logic              code_start, code_active, code_done;
    logic [CODE_W-1:0] code_word;
    sel_kind_e         code_kind;

    assign code_start  = (st_q == ST_ARMED) && !swdio_in;
    assign code_active = (st_q == ST_SHIFT);

    swj_run_counter #(
        .CNT_W     (CNT_W),
        .RESET_LEN (RESET_LEN)
    ) u_run (
        .clk    (clk),
        .rst    (rst),
        .bit_in (swdio_in),
        .clr    (code_done),
        .run_o  (run_cnt),
        .hit_o  (lr_hit)
    );

    swj_code_shift #(
        .CODE_W (CODE_W)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .bit_in (swdio_in),
        .start  (code_start),
        .active (code_active),
        .code_o (code_word),
        .done_o (code_done)
    );

    assign code_kind = classify_code(code_word);

    always_comb begin
        st_d       = st_q;
        pend_swd_d = pend_swd_q;
        out_d      = '{swd: out_q.swd, chg: 1'b0, tap: 1'b0};
        case (st_q)
            ST_IDLE: begin
                if (lr_hit) st_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!swdio_in) st_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (code_done) begin
                    case (code_kind)
                        SEL_TO_SWD: begin
                            st_d       = ST_TRAIL;
                            pend_swd_d = 1'b1;
                        end
                        SEL_TO_JTAG: begin
                            st_d       = ST_TRAIL;
                            pend_swd_d = 1'b0;
                        end
                        default: st_d = ST_IDLE;
                    endcase
                end
            end
            ST_TRAIL: begin
                if (!swdio_in) begin
                    st_d = ST_IDLE;
                end else if (lr_hit) begin
                    st_d = ST_ARMED;
                    if (pend_swd_q != out_q.swd) begin
                        out_d.swd = pend_swd_q;
                        out_d.chg = 1'b1;
                        out_d.tap = !pend_swd_q;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            pend_swd_q <= 1'b0;
            out_q      <= '0;
        end else begin
            st_q       <= st_d;
            pend_swd_q <= pend_swd_d;
            out_q      <= out_d;
        end
    end

    assign mode_swd    = out_q.swd;
    assign mode_chg    = out_q.chg;
    assign tap_rst_req = out_q.tap;

endmodule

// File: rtl/swj_mode_detect_chk.sv
module swj_mode_detect_chk #(
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             line_in,
    input logic             mode_swd,
    input logic             mode_chg,
    input logic             tap_rst_req,
    input logic [CNT_W-1:0] run
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    AST_RESET_JTAG: assert property (@(posedge clk) $past(rst) |-> (!mode_swd && !mode_chg && !tap_rst_req)); // R1

    AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (rst) (mode_swd != $past(mode_swd)) |-> mode_chg); // R7

    AST_FLAG_MEANS_CHANGE: assert property (@(posedge clk) disable iff (rst) mode_chg |-> (mode_swd != $past(mode_swd))); // R7

    AST_FLAG_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) mode_chg |=> !mode_chg); // R7

    AST_COMMIT_ON_HIGH: assert property (@(posedge clk) disable iff (rst) mode_chg |-> $past(line_in)); // R6

    AST_TAP_ONLY_JTAG: assert property (@(posedge clk) disable iff (rst) tap_rst_req |-> (mode_chg && !mode_swd)); // R8

    AST_TAP_ON_ENTRY: assert property (@(posedge clk) disable iff (rst) (mode_chg && !mode_swd) |-> tap_rst_req); // R8

    AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (rst) (run == RUN_MAX && line_in) |=> (run == RUN_MAX)); // R9

endmodule

bind swj_mode_detect swj_mode_detect_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .line_in     (swdio_in),
    .mode_swd    (mode_swd),
    .mode_chg    (mode_chg),
    .tap_rst_req (tap_rst_req),
    .run         (run_cnt)
);

// File: tb/swj_mode_detect_tb.sv
`timescale 1ns/1ps
module swj_mode_detect_tb;

    typedef struct {
        logic  swd;
        logic  chg;
        logic  tap;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line = 1'b1;
    logic mode_swd, mode_chg, tap_rst_req;

    int   n_cmp  = 0;
    int   n_bad  = 0;
    logic cur    = 1'b0;
    bit   finished = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    swj_mode_detect u_dut (
        .clk         (clk),
        .rst         (rst),
        .swdio_in    (line),
        .mode_swd    (mode_swd),
        .mode_chg    (mode_chg),
        .tap_rst_req (tap_rst_req)
    );

    // monitor: one expected item per rising edge after it was driven
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            n_cmp++;
            if (mode_swd !== e.swd || mode_chg !== e.chg || tap_rst_req !== e.tap) begin
                n_bad++;
                $display("FAIL %s: got swd=%0b chg=%0b tap=%0b exp swd=%0b chg=%0b tap=%0b",
                         e.tag, mode_swd, mode_chg, tap_rst_req, e.swd, e.chg, e.tap);
            end
        end
    end

    task automatic drive(input logic b, input logic e_swd, input logic e_chg,
                         input logic e_tap, input string tag);
        exp_t e;
        @(negedge clk);
        line = b;
        e.swd = e_swd; e.chg = e_chg; e.tap = e_tap; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic ones(input int n, input string tag);
        for (int i = 0; i < n; i++) drive(1'b1, cur, 1'b0, 1'b0, tag);
    endtask

    task automatic send_code(input logic [15:0] c, input string tag);
        for (int i = 0; i < 16; i++) drive(c[i], cur, 1'b0, 1'b0, tag);
    endtask

    // trailing run: on the 50th one the switch (if any) becomes visible
    task automatic trail(input int n, input bit do_sw, input logic new_mode, input string tag);
        for (int i = 0; i < n; i++) begin
            if (do_sw && i == 49) begin
                cur = new_mode;
                drive(1'b1, cur, 1'b1, !new_mode, tag);
            end else begin
                drive(1'b1, cur, 1'b0, 1'b0, tag);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (mode_swd !== 1'b0 || mode_chg !== 1'b0 || tap_rst_req !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 in reset: got swd=%0b chg=%0b tap=%0b exp 0 0 0",
                     mode_swd, mode_chg, tap_rst_req);
        end
        rst = 1'b0;

        // R2 R3: line reset, current serial-wire code, trailing reset
        ones(50, "R2 line reset");
        send_code(16'hE79E, "R3 swd code");
        trail(50, 1, 1'b1, "R3 R7 enter swd");

        // R3 R8: current JTAG code
        send_code(16'hE73C, "R3 jtag code");
        trail(50, 1, 1'b0, "R3 R8 enter jtag");

        // R4: deprecated codes both ways
        send_code(16'hEDB6, "R4 old swd code");
        trail(50, 1, 1'b1, "R4 enter swd");
        send_code(16'hDEAE, "R4 old jtag code");
        trail(50, 1, 1'b0, "R4 R8 enter jtag");

        // R7: same-mode request gives no pulse
        send_code(16'hDEAE, "R7 same mode code");
        trail(50, 0, 1'b0, "R7 no pulse");

        // R5: unknown pattern, then valid code without a new line reset
        send_code(16'h1234, "R5 unknown code");
        send_code(16'hE79E, "R5 code without reset");
        trail(50, 0, 1'b0, "R5 ignored");

        // R2: 49 ones is not a line reset
        send_code(16'h1234, "R2 disarm");
        ones(49, "R2 short run");
        send_code(16'hE79E, "R2 code after short run");
        trail(50, 0, 1'b0, "R2 ignored");

        // R6: zero inside trailing run cancels
        send_code(16'hE79E, "R6 code");
        ones(20, "R6 partial trail");
        drive(1'b0, cur, 1'b0, 1'b0, "R6 cancel zero");
        ones(50, "R6 no switch");

        // R6: exact commit edge
        send_code(16'hE79E, "R6 code");
        trail(50, 1, 1'b1, "R6 commit on 50th one");

        // R9: long idle-high, then a code still works
        ones(200, "R9 long idle");
        send_code(16'hE73C, "R9 code after idle");
        trail(50, 1, 1'b0, "R9 R8 enter jtag");
        ones(5, "R9 tail");

        wait (q.size() == 0);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule